// File: doc/BRIEF.md
# OLED Controller Command Interpreter

This block sits behind the serial slave of a small dot-matrix OLED controller. Every received byte comes with the level of the command/data select line. Bytes sent with the line low are commands: some act alone, others are followed by one or four argument bytes that load configuration registers. Bytes sent with the line high are pixel data. Each one is written into a display memory of 132 columns by 8 pages. One byte covers 8 vertically stacked pixels of one column. Writes go to a page/column pointer that steps one column after each byte.

A decode state machine has two states. `ST_OPCODE` waits for a command byte. `ST_ARG` collects argument bytes for the pending opcode and counts down how many are still owed. The state machine has five named transitions:
- `T_SINGLE`: an opcode that takes no argument leaves the machine in `ST_OPCODE`.
- `T_TAKE_OP`: an opcode that takes arguments moves the machine from `ST_OPCODE` to `ST_ARG`.
- `T_NEXT_ARG`: a non-final argument keeps the machine in `ST_ARG`.
- `T_LAST_ARG`: the final argument returns the machine to `ST_OPCODE`.
- `T_ABORT`: a data-line byte received in `ST_ARG` returns the machine to `ST_OPCODE` and is stored as pixel data.

Data-line bytes received in `ST_OPCODE` are also written as pixels. The configuration values, the pointers and a registered read port into display memory are all brought out, for a scan-out engine or a model.

Top module: `oled_cmd_interp`

## Requirements
- R1: After reset, the display-on flag is 0, inverse polarity is 0, segment remap and scan flip are 0, the page and column pointers are 0, and the decoder is waiting for an opcode. Display memory is not cleared.
- R2: A command byte 0xB0 + p with p below 8 sets the page pointer to p. Command bytes 0xB8..0xBF leave the page pointer unchanged.
- R3: Command bytes 0x00..0x0F load bits [3:0] of the 8-bit column pointer from the byte's low nibble. Command bytes 0x10..0x1F load bits [7:4] from the byte's low nibble.
- R4: A data-line byte is stored at the current page and column. Placing the page and column on the read port returns it one clock later.
- R5: After each data-line byte, the column pointer goes from c to c+1, and from 131 to 0. The page pointer does not change.
- R6: Each of the following opcodes stores the next command-line byte in its register, and that byte is not decoded as a command:
  - 0xD5 → clk_div
  - 0xA8 → mux_ratio
  - 0xD3 → disp_offset
  - 0xAD → pwr_cfg
  - 0x20 → addr_mode
  - 0xDA → com_pins
  - 0x81 → contrast
  - 0x82 → brightness
  - 0xD9 → precharge
  - 0xDB → vcomh_lvl
- R7: Opcode 0x91 takes four argument bytes. The k-th argument (k = 0..3) goes to pulse_w[8k+7:8k].
- R8: Flag and start-line opcodes:
  - 0xAE clears the display-on flag and 0xAF sets it.
  - 0xA6 clears inverse polarity and 0xA7 sets it.
  - 0xA0 and 0xA1 clear and set segment remap.
  - 0xC0 and 0xC8 clear and set scan flip.
  - 0x40..0x7F load start_line from bits [5:0].
- R9: A data-line byte that arrives while arguments are still owed ends the pending command. The byte is written as pixel data, the arguments already received are kept, and the next command-line byte is decoded as an opcode.
- R10: A command byte that is not listed in R2, R3, R6, R7 or R8 changes no output, and the next command-line byte is decoded as an opcode.
- R11: A data-line byte received while the column pointer is above 131 is not written anywhere, and the column pointer becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_is_data | input | 1 | Command/data select: 1 = pixel data, 0 = command or argument |
| rx_byte | input | 8 | Received byte |
| rd_page | input | 3 | Read port page |
| rd_col | input | 8 | Read port column |
| rd_data | output | 8 | Read data, one clock after address |
| disp_on | output | 1 | Display-on flag |
| invert | output | 1 | Inverse polarity |
| seg_remap | output | 1 | Segment remap |
| com_flip | output | 1 | Scan direction flip |
| start_line | output | 6 | Display start line |
| clk_div | output | 8 | Clock divide/oscillator argument |
| mux_ratio | output | 8 | Multiplex ratio argument |
| disp_offset | output | 8 | Display offset argument |
| pwr_cfg | output | 8 | Power configuration argument |
| addr_mode | output | 8 | Addressing mode argument (stored only) |
| com_pins | output | 8 | Common pin layout argument |
| contrast | output | 8 | Contrast argument |
| brightness | output | 8 | Area brightness argument |
| precharge | output | 8 | Precharge period argument |
| vcomh_lvl | output | 8 | Deselect level argument |
| pulse_w | output | 32 | Four drive pulse width arguments |
| page_ptr | output | 3 | Current page pointer |
| col_ptr | output | 8 | Current column pointer |

## Verification
On every cycle, the assertions check the following:
- the pointer reset values;
- the column step and wrap after each data byte, with the page held steady;
- the page load from a page command decoded as an opcode;
- the display-on flag commands;
- entry into argument collection after a one-argument opcode;
- the abort to opcode wait on a data-line byte.

Only the bench scenarios can show the contents and placement of display memory. This covers the full 8 × 132 fill and read-back, and the dropped write past column 131 that must not alias into the next page. The bench scenarios also cover the order of bytes within the four-argument opcode, argument bytes that look like column or page commands, and the fact that unknown opcodes leave every output untouched.

// File: rtl/oled_ctl_pkg.sv
package oled_ctl_pkg;

    typedef enum logic {
        ST_OPCODE = 1'b0,
        ST_ARG    = 1'b1
    } dec_state_e;

    typedef struct packed {
        logic        disp_on;
        logic        invert;
        logic        seg_remap;
        logic        com_flip;
        logic [5:0]  start_line;
        logic [7:0]  clk_div;
        logic [7:0]  mux_ratio;
        logic [7:0]  disp_offset;
        logic [7:0]  pwr_cfg;
        logic [7:0]  addr_mode;
        logic [7:0]  com_pins;
        logic [7:0]  contrast;
        logic [7:0]  brightness;
        logic [7:0]  precharge;
        logic [7:0]  vcomh_lvl;
        logic [31:0] pulse_w;
    } cfg_t;

    // Number of argument bytes that follow an opcode.
    function automatic logic [2:0] arg_count(input logic [7:0] op);
        case (op)
            8'hD5, 8'hA8, 8'hD3, 8'hAD, 8'h20,
            8'hDA, 8'h81, 8'h82, 8'hD9, 8'hDB: return 3'd1;
            8'h91:                             return 3'd4;
            default:                           return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/oled_cmd_fsm.sv
module oled_cmd_fsm
    import oled_ctl_pkg::*;
#(
    parameter int PAGES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic       rx_is_data,
    input  logic [7:0] rx_byte,
    output cfg_t       cfg_o,
    output logic       arg_wait_o,
    output logic       lo_set_o,
    output logic       hi_set_o,
    output logic       page_set_o,
    output logic       data_wr_o
);

    dec_state_e state_q, state_d;
    logic [2:0] left_q, left_d;
    logic [7:0] op_q, op_d;
    logic [1:0] idx_q, idx_d;
    logic       take_op, take_arg;
    cfg_t       cfg_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPCODE;
            left_q  <= '0;
            op_q    <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            op_q    <= op_d;
            idx_q   <= idx_d;
        end
    end

    // Next state and transition decode
    always_comb begin
        state_d  = state_q;
        left_d   = left_q;
        op_d     = op_q;
        idx_d    = idx_q;
        take_op  = 1'b0;
        take_arg = 1'b0;
        if (rx_valid) begin
            unique case (state_q)
                ST_OPCODE: begin
                    if (!rx_is_data) begin
                        take_op = 1'b1;
                        if (arg_count(rx_byte) != 3'd0) begin   // T_TAKE_OP
                            state_d = ST_ARG;
                            left_d  = arg_count(rx_byte);
                            op_d    = rx_byte;
                            idx_d   = '0;
                        end                                     // else T_SINGLE
                    end
                end
                ST_ARG: begin
                    if (rx_is_data) begin                       // T_ABORT
                        state_d = ST_OPCODE;
                        left_d  = '0;
                    end else begin
                        take_arg = 1'b1;
                        left_d   = left_q - 3'd1;
                        idx_d    = idx_q + 2'd1;
                        if (left_q == 3'd1) state_d = ST_OPCODE; // T_LAST_ARG
                                                                 // else T_NEXT_ARG
                    end
                end
            endcase
        end
    end

    // Output registers: configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (take_op) begin
            if (rx_byte[7:6] == 2'b01) cfg_q.start_line <= rx_byte[5:0];
            case (rx_byte)
                8'hAE: cfg_q.disp_on   <= 1'b0;
                8'hAF: cfg_q.disp_on   <= 1'b1;
                8'hA6: cfg_q.invert    <= 1'b0;
                8'hA7: cfg_q.invert    <= 1'b1;
                8'hA0: cfg_q.seg_remap <= 1'b0;
                8'hA1: cfg_q.seg_remap <= 1'b1;
                8'hC0: cfg_q.com_flip  <= 1'b0;
                8'hC8: cfg_q.com_flip  <= 1'b1;
                default: ;
            endcase
        end else if (take_arg) begin
            case (op_q)
                8'hD5: cfg_q.clk_div     <= rx_byte;
                8'hA8: cfg_q.mux_ratio   <= rx_byte;
                8'hD3: cfg_q.disp_offset <= rx_byte;
                8'hAD: cfg_q.pwr_cfg     <= rx_byte;
                8'h20: cfg_q.addr_mode   <= rx_byte;
                8'hDA: cfg_q.com_pins    <= rx_byte;
                8'h81: cfg_q.contrast    <= rx_byte;
                8'h82: cfg_q.brightness  <= rx_byte;
                8'hD9: cfg_q.precharge   <= rx_byte;
                8'hDB: cfg_q.vcomh_lvl   <= rx_byte;
                8'h91: cfg_q.pulse_w[{idx_q, 3'b000} +: 8] <= rx_byte;
                default: ;
            endcase
        end
    end

    assign cfg_o      = cfg_q;
    assign arg_wait_o = (state_q == ST_ARG);
    assign lo_set_o   = take_op && (rx_byte[7:4] == 4'h0);
    assign hi_set_o   = take_op && (rx_byte[7:4] == 4'h1);
    assign page_set_o = take_op && (rx_byte[7:4] == 4'hB) && (int'(rx_byte[3:0]) < PAGES);
    assign data_wr_o  = rx_valid && rx_is_data;

endmodule

// File: rtl/oled_addr_ptr.sv
module oled_addr_ptr #(
    parameter int COLS   = 132,
    parameter int PAGES  = 8,
    parameter int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_set,
    input  logic              hi_set,
    input  logic              page_set,
    input  logic              data_wr,
    input  logic [3:0]        nib,
    output logic [7:0]        col_q,
    output logic [PAGE_W-1:0] page_q,
    output logic              wr_ok
);

    localparam logic [7:0] LAST_COL = 8'(COLS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            page_q <= '0;
        end else begin
            if (page_set) page_q <= nib[PAGE_W-1:0];
            if (lo_set)   col_q[3:0] <= nib;
            if (hi_set)   col_q[7:4] <= nib;
            if (data_wr)  col_q <= (col_q >= LAST_COL) ? 8'd0 : col_q + 8'd1;
        end
    end

    assign wr_ok = data_wr && (col_q <= LAST_COL);

endmodule

// File: rtl/oled_gdram.sv
module oled_gdram #(
    parameter int COLS   = 132,
    parameter int PAGES  = 8,
    parameter int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PAGE_W-1:0] wpage,
    input  logic [7:0]        wcol,
    input  logic [7:0]        wdata,
    input  logic [PAGE_W-1:0] rpage,
    input  logic [7:0]        rcol,
    output logic [7:0]        rdata
);

    localparam int DEPTH = COLS * PAGES;
    localparam int AW    = $clog2(DEPTH + 256);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] waddr, raddr;

    assign waddr = AW'(wpage) * AW'(COLS) + AW'(wcol);
    assign raddr = AW'(rpage) * AW'(COLS) + AW'(rcol);

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= (int'(rcol) < COLS) ? mem[raddr] : 8'h00;
    end

endmodule

// File: rtl/oled_cmd_interp.sv
module oled_cmd_interp
    import oled_ctl_pkg::*;
#(
    parameter  int COLS   = 132,
    parameter  int PAGES  = 8,
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_is_data,
    input  logic [7:0]        rx_byte,
    input  logic [PAGE_W-1:0] rd_page,
    input  logic [7:0]        rd_col,
    output logic [7:0]        rd_data,
    output logic              disp_on,
    output logic              invert,
    output logic              seg_remap,
    output logic              com_flip,
    output logic [5:0]        start_line,
    output logic [7:0]        clk_div,
    output logic [7:0]        mux_ratio,
    output logic [7:0]        disp_offset,
    output logic [7:0]        pwr_cfg,
    output logic [7:0]        addr_mode,
    output logic [7:0]        com_pins,
    output logic [7:0]        contrast,
    output logic [7:0]        brightness,
    output logic [7:0]        precharge,
    output logic [7:0]        vcomh_lvl,
    output logic [31:0]       pulse_w,
    output logic [PAGE_W-1:0] page_ptr,
    output logic [7:0]        col_ptr
);

    cfg_t cfg;
    logic arg_wait, lo_set, hi_set, page_set, data_wr, wr_ok;

    oled_cmd_fsm #(.PAGES(PAGES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_is_data (rx_is_data),
        .rx_byte    (rx_byte),
        .cfg_o      (cfg),
        .arg_wait_o (arg_wait),
        .lo_set_o   (lo_set),
        .hi_set_o   (hi_set),
        .page_set_o (page_set),
        .data_wr_o  (data_wr)
    );

    oled_addr_ptr #(.COLS(COLS), .PAGES(PAGES), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_set   (lo_set),
        .hi_set   (hi_set),
        .page_set (page_set),
        .data_wr  (data_wr),
        .nib      (rx_byte[3:0]),
        .col_q    (col_ptr),
        .page_q   (page_ptr),
        .wr_ok    (wr_ok)
    );

    oled_gdram #(.COLS(COLS), .PAGES(PAGES), .PAGE_W(PAGE_W)) u_ram (
        .clk   (clk),
        .we    (wr_ok),
        .wpage (page_ptr),
        .wcol  (col_ptr),
        .wdata (rx_byte),
        .rpage (rd_page),
        .rcol  (rd_col),
        .rdata (rd_data)
    );

    assign disp_on     = cfg.disp_on;
    assign invert      = cfg.invert;
    assign seg_remap   = cfg.seg_remap;
    assign com_flip    = cfg.com_flip;
    assign start_line  = cfg.start_line;
    assign clk_div     = cfg.clk_div;
    assign mux_ratio   = cfg.mux_ratio;
    assign disp_offset = cfg.disp_offset;
    assign pwr_cfg     = cfg.pwr_cfg;
    assign addr_mode   = cfg.addr_mode;
    assign com_pins    = cfg.com_pins;
    assign contrast    = cfg.contrast;
    assign brightness  = cfg.brightness;
    assign precharge   = cfg.precharge;
    assign vcomh_lvl   = cfg.vcomh_lvl;
    assign pulse_w     = cfg.pulse_w;

endmodule

// File: rtl/oled_cmd_interp_chk.sv
module oled_cmd_interp_chk #(
    parameter  int COLS   = 132,
    parameter  int PAGES  = 8,
    localparam int PAGE_W = $clog2(PAGES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_is_data,
    input logic [7:0]        rx_byte,
    input logic              arg_wait,
    input logic [PAGE_W-1:0] page_ptr,
    input logic [7:0]        col_ptr,
    input logic              disp_on
);

    localparam logic [7:0] LAST_COL = 8'(COLS - 1);

    // R1: pointers and display flag come out of reset cleared
    p_reset_vals_r1: assert property (@(posedge clk)
        !rst_n |=> (col_ptr == 8'd0 && page_ptr == '0 && !disp_on && !arg_wait));

    // R5 / R11: column steps or wraps after a data byte
    p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_is_data) |=>
            col_ptr == (($past(col_ptr) >= LAST_COL) ? 8'd0 : $past(col_ptr) + 8'd1));

    // R5: page unchanged by data bytes
    p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_is_data) |=> $stable(page_ptr));

    // R2: page command decoded as opcode loads the page
    p_page_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_is_data && !arg_wait && rx_byte[7:4] == 4'hB
         && int'(rx_byte[3:0]) < PAGES)
        |=> page_ptr == $past(rx_byte[PAGE_W-1:0]));

    // R8: display on/off opcodes
    p_disp_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_is_data && !arg_wait && (rx_byte == 8'hAE || rx_byte == 8'hAF))
        |=> disp_on == $past(rx_byte[0]));

    // R6: one-argument opcode opens argument collection
    p_arg_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_is_data && !arg_wait && rx_byte == 8'h81) |=> arg_wait);

    // R9: data byte closes any pending command
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_is_data) |=> !arg_wait);

endmodule

bind oled_cmd_interp oled_cmd_interp_chk #(.COLS(COLS), .PAGES(PAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_is_data (rx_is_data),
    .rx_byte    (rx_byte),
    .arg_wait   (arg_wait),
    .page_ptr   (page_ptr),
    .col_ptr    (col_ptr),
    .disp_on    (disp_on)
);

// File: tb/oled_cmd_interp_tb.sv
module oled_cmd_interp_tb;

    localparam int COLS  = 132;
    localparam int PAGES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_is_data = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [2:0]  rd_page = 3'd0;
    logic [7:0]  rd_col = 8'd0;
    logic [7:0]  rd_data;
    logic        disp_on, invert, seg_remap, com_flip;
    logic [5:0]  start_line;
    logic [7:0]  clk_div, mux_ratio, disp_offset, pwr_cfg, addr_mode, com_pins;
    logic [7:0]  contrast, brightness, precharge, vcomh_lvl;
    logic [31:0] pulse_w;
    logic [2:0]  page_ptr;
    logic [7:0]  col_ptr;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    oled_cmd_interp #(.COLS(COLS), .PAGES(PAGES)) u_dut (
        .clk, .rst_n, .rx_valid, .rx_is_data, .rx_byte, .rd_page, .rd_col, .rd_data,
        .disp_on, .invert, .seg_remap, .com_flip, .start_line, .clk_div, .mux_ratio,
        .disp_offset, .pwr_cfg, .addr_mode, .com_pins, .contrast, .brightness,
        .precharge, .vcomh_lvl, .pulse_w, .page_ptr, .col_ptr
    );

    task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; byte is captured at the next rising edge.
    task automatic send(input logic is_data, input logic [7:0] b);
        rx_valid   = 1'b1;
        rx_is_data = is_data;
        rx_byte    = b;
        @(negedge clk);
        rx_valid   = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);
        send(1'b0, b);
    endtask

    task automatic rd(input int p, input int c, output logic [7:0] v);
        rd_page = 3'(p);
        rd_col  = 8'(c);
        @(negedge clk);
        v = rd_data;
    endtask

    function automatic logic [7:0] pat(input int p, input int c);
        return 8'((p * 29 + c * 7 + 90) & 255);
    endfunction

    function automatic logic [159:0] snap();
        return {27'd0, disp_on, invert, seg_remap, com_flip, start_line, clk_div,
                mux_ratio, disp_offset, pwr_cfg, addr_mode, com_pins, contrast,
                brightness, precharge, vcomh_lvl, pulse_w, page_ptr, col_ptr};
    endfunction

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [159:0] s0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 disp_on", disp_on, 0);
        chk("R1 invert", invert, 0);
        chk("R1 seg/com", {seg_remap, com_flip}, 0);
        chk("R1 page", page_ptr, 0);
        chk("R1 col", col_ptr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 / R7 / R8 power-up style sequence
        cmd(8'hAE); cmd(8'hD5); cmd(8'h10); cmd(8'hA8); cmd(8'h1F);
        cmd(8'hD3); cmd(8'h05); cmd(8'h40); cmd(8'hAD); cmd(8'h8E);
        cmd(8'h20); cmd(8'h02); cmd(8'hA0); cmd(8'hC8); cmd(8'hDA); cmd(8'h12);
        cmd(8'h91); cmd(8'h3F); cmd(8'h3E); cmd(8'h3D); cmd(8'h3C);
        cmd(8'h81); cmd(8'hFF); cmd(8'h82); cmd(8'h7F); cmd(8'hD9); cmd(8'hD2);
        cmd(8'hDB); cmd(8'h08); cmd(8'hA4); cmd(8'hA6); cmd(8'hAF);
        chk("R6 clk_div", clk_div, 8'h10);
        chk("R6 mux_ratio", mux_ratio, 8'h1F);
        chk("R6 disp_offset", disp_offset, 8'h05);
        chk("R6 arg not col cmd", col_ptr, 0);
        chk("R6 pwr_cfg", pwr_cfg, 8'h8E);
        chk("R6 addr_mode", addr_mode, 8'h02);
        chk("R6 com_pins", com_pins, 8'h12);
        chk("R6 contrast", contrast, 8'hFF);
        chk("R6 brightness", brightness, 8'h7F);
        chk("R6 precharge", precharge, 8'hD2);
        chk("R6 vcomh_lvl", vcomh_lvl, 8'h08);
        chk("R7 pulse_w order", pulse_w, 32'h3C3D3E3F);
        chk("R8 disp_on", disp_on, 1);
        chk("R8 com_flip", com_flip, 1);
        chk("R8 seg_remap", seg_remap, 0);
        chk("R8 invert", invert, 0);

        // R8 flag toggles and start-line sweep
        cmd(8'hA7); chk("R8 invert set", invert, 1);
        cmd(8'hA6); chk("R8 invert clr", invert, 0);
        cmd(8'hA1); chk("R8 remap set", seg_remap, 1);
        cmd(8'hC0); chk("R8 flip clr", com_flip, 0);
        cmd(8'hAE); chk("R8 off", disp_on, 0);
        cmd(8'hAF); chk("R8 on", disp_on, 1);
        for (int i = 0; i < 64; i++) begin
            cmd(8'(8'h40 + i));
            chk("R8 start_line", start_line, i);
        end

        // R2 page commands
        for (int p = 0; p < PAGES; p++) begin
            cmd(8'(8'hB0 + p));
            chk("R2 page set", page_ptr, p);
        end
        cmd(8'hB8); chk("R2 page B8 ignored", page_ptr, 7);

        // R3 column nibbles
        for (int c = 0; c < COLS; c++) begin
            cmd(8'(c & 15));
            cmd(8'(8'h10 | (c >> 4)));
            chk("R3 col set", col_ptr, c);
        end

        // R4 / R5 fill all pages
        for (int p = 0; p < PAGES; p++) begin
            cmd(8'(8'hB0 + p)); cmd(8'h00); cmd(8'h10);
            for (int c = 0; c < COLS; c++) begin
                send(1'b1, pat(p, c));
                chk("R5 col step", col_ptr, (c + 1) % COLS);
                chk("R5 page hold", page_ptr, p);
            end
        end
        for (int p = 0; p < PAGES; p++) begin
            for (int c = 0; c < COLS; c++) begin
                rd(p, c, v);
                chk("R4 readback", v, pat(p, c));
            end
        end

        // R11 write past column 131 dropped
        cmd(8'hB2); cmd(8'h0F); cmd(8'h18);
        chk("R3 col 143", col_ptr, 143);
        send(1'b1, 8'hEE);
        chk("R11 col wraps", col_ptr, 0);
        chk("R11 page kept", page_ptr, 2);
        rd(3, 11, v); chk("R11 no alias", v, pat(3, 11));
        rd(2, 131, v); chk("R11 last col kept", v, pat(2, 131));
        rd(2, 0, v); chk("R11 col0 kept", v, pat(2, 0));

        // R9 abort of pending arguments
        cmd(8'hB4); cmd(8'h03); cmd(8'h10);
        cmd(8'h81); send(1'b1, 8'h77);
        chk("R9 contrast kept", contrast, 8'hFF);
        chk("R9 col advanced", col_ptr, 4);
        rd(4, 3, v); chk("R9 data written", v, 8'h77);
        cmd(8'hA7); chk("R9 next is opcode", invert, 1);
        cmd(8'h91); cmd(8'h11); cmd(8'h22); send(1'b1, 8'h33);
        chk("R9 partial args kept", pulse_w, 32'h3C3D2211);
        rd(4, 4, v); chk("R9 data after 0x91", v, 8'h33);
        cmd(8'hB5); chk("R9 page opcode decoded", page_ptr, 5);

        // R10 unknown opcodes
        s0 = snap();
        cmd(8'h8E); chk("R10 8E no-op", snap(), s0);
        cmd(8'hE3); chk("R10 E3 no-op", snap(), s0);
        cmd(8'hFF); chk("R10 FF no-op", snap(), s0);
        cmd(8'hBC); chk("R10 BC no-op", snap(), s0);
        cmd(8'hAE); chk("R10 next is opcode", disp_on, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule